// File: doc/BRIEF.md
# Priority Interrupt Controller with Aging

This block gathers interrupt requests from eight maskable sources and one non-maskable source. It presents the single most urgent request to a processor as an interrupt line plus a vector. Each source has a fixed rank. A mask register lets software hold back individual maskable sources. A masked request is not held back forever: once it has waited long enough, it is promoted and must be serviced.

Services can nest. When the processor accepts a request while another service is running, the level of the running service is saved on an internal stack of levels. When the processor signals end of service, the saved level is restored. A new request raises the interrupt line only when its rank is strictly above the level currently being serviced. A small write port sets the mask bits and the aging threshold.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq_o` is 0, `vec_o` is 0 and `cur_lvl_o` is 9 (idle). All mask bits are 0 and the aging threshold is `AGE_RST` (15).
- R2: A source becomes pending on a 0-to-1 transition of its input. Holding the input high does not make it pending again after it has been acknowledged. An acknowledge clears the pending flag of the acknowledged source.
- R3: Among eligible requests, the non-maskable one wins, then the lowest source index. `vec_o` carries the source index 0..7 or the value 8 for the non-maskable source, and it reads 0 whenever `irq_o` is 0.
- R4: A write with `wr_sel_i`=0 loads the mask from `wr_data_i[7:0]`, where bit k=1 holds back source k. A write with `wr_sel_i`=1 loads the aging threshold from `wr_data_i[7:0]`. A write takes effect on the outputs in the cycle after its edge.
- R5: The non-maskable input is never held back by any mask bit and ranks above every maskable source. Its service level is 0.
- R6: A source that stays pending and masked for threshold+1 consecutive cycles becomes forced. A forced source is eligible as if unmasked until it is acknowledged. The wait count restarts when the source is unmasked, serviced or not pending.
- R7: `irq_o` is 1 exactly when an eligible request exists whose level is numerically below `cur_lvl_o`. Source k has level k+1 and idle is 9. Outputs reflect each state change in the cycle after the clock edge that caused it.
- R8: `ack_i` is taken only while `irq_o` is 1. When taken, it saves the current level on the stack and sets `cur_lvl_o` to the level of the presented vector. When `irq_o` is 0, `ack_i` changes nothing.
- R9: `eos_i` restores the most recently saved level. It is ignored when no service is active, and it is ignored in a cycle where an acknowledge is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 8 | Maskable request inputs, index 0 highest |
| nmi_i | input | 1 | Non-maskable request input |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 1 | 0 selects the mask, 1 selects the aging threshold |
| wr_data_i | input | 16 | Configuration write data |
| ack_i | input | 1 | Processor accepts the presented vector |
| eos_i | input | 1 | Processor finished the current service |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 4 | Presented vector: 0..7 sources, 8 non-maskable |
| cur_lvl_o | output | 4 | Level of the active service, 9 when idle |

## Verification
A corrupted pending flag, wait counter or forced flag shows up at the ports in the first cycle in which that source would otherwise be the winning eligible request. This appears as a missing or extra `irq_o`, or as a wrong `vec_o`. A wrong saved level stays hidden until the matching end of service. In that cycle `cur_lvl_o` takes the wrong value, and `irq_o` may also change for requests that are waiting. The bench therefore compares all three outputs against a behavioural model on every cycle, so that such faults are caught in the cycle where they first become visible.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  // selector of the configuration write port
  typedef enum logic {
    CFG_MASK = 1'b0,
    CFG_AGE  = 1'b1
  } cfg_sel_e;

endpackage

// File: rtl/prio_irq_capture.sv
// Edge-triggered pending flags, one per request input.
module prio_irq_capture #(
  parameter int unsigned N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_q_o,
  output logic [N-1:0] pend_d_o
);

  for (genvar g = 0; g < N; g++) begin : g_req
    logic prev_q;
    logic pend_q;
    logic pend_d;

    always_comb pend_d = (pend_q & ~clr_i[g]) | (req_i[g] & ~prev_q);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= req_i[g];
        pend_q <= pend_d;
      end
    end

    assign pend_q_o[g] = pend_q;
    assign pend_d_o[g] = pend_d;
  end

endmodule

// File: rtl/prio_irq_age.sv
// Per-source wait counters that promote long-masked requests.
module prio_irq_age #(
  parameter int unsigned N     = 8,
  parameter int unsigned AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     svc_i,
  input  logic [AGE_W-1:0] thr_i,
  output logic [N-1:0]     force_q_o,
  output logic [N-1:0]     force_d_o
);

  for (genvar g = 0; g < N; g++) begin : g_src
    logic [AGE_W-1:0] cnt_q;
    logic [AGE_W-1:0] cnt_d;
    logic             frc_q;
    logic             frc_d;
    logic             waiting;

    always_comb begin
      waiting = pend_i[g] & mask_i[g] & ~frc_q & ~svc_i[g];
      frc_d   = (frc_q & ~svc_i[g]) | (waiting & (cnt_q >= thr_i));
      cnt_d   = waiting ? cnt_q + AGE_W'(1) : '0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
        frc_q <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        frc_q <= frc_d;
      end
    end

    assign force_q_o[g] = frc_q;
    assign force_d_o[g] = frc_d;
  end

endmodule

// File: rtl/prio_irq_select.sv
// Fixed-rank selection: non-maskable first, then lowest index.
module prio_irq_select #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 4
) (
  input  logic [N-1:0] elig_i,
  input  logic         nmi_i,
  output logic         any_o,
  output logic [W-1:0] id_o,
  output logic [W-1:0] lvl_o
);

  localparam logic [W-1:0] NMI_ID = W'(N);
  localparam logic [W-1:0] IDLE   = W'(N + 1);

  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        any_o = 1'b1;
        id_o  = W'(i);
      end
    end
    if (nmi_i) begin
      any_o = 1'b1;
      id_o  = NMI_ID;
    end
    if (!any_o)
      lvl_o = IDLE;
    else if (id_o == NMI_ID)
      lvl_o = '0;
    else
      lvl_o = id_o + W'(1);
  end

endmodule

// File: rtl/prio_irq_stack.sv
// LIFO of saved service levels.
module prio_irq_stack #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned W     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);

  localparam int unsigned PW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp_q;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == PW'(DEPTH));
  assign wr_idx  = AW'(sp_q);
  assign rd_idx  = AW'(sp_q - PW'(1));
  assign top_o   = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push_i && !full_o)
      mem[wr_idx] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst)
      sp_q <= '0;
    else if (push_i && !full_o)
      sp_q <= sp_q + PW'(1);
    else if (pop_i && !empty_o)
      sp_q <= sp_q - PW'(1);
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Priority interrupt controller with masking, aging and nested service levels.
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned AGE_W   = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned AGE_RST = 15
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_SRC-1:0]               src_i,
  input  logic                             nmi_i,
  input  logic                             wr_en_i,
  input  logic                             wr_sel_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic                             ack_i,
  input  logic                             eos_i,
  output logic                             irq_o,
  output logic [$clog2(NUM_SRC+2)-1:0]     vec_o,
  output logic [$clog2(NUM_SRC+2)-1:0]     cur_lvl_o
);

  localparam int unsigned W     = $clog2(NUM_SRC + 2);
  localparam int unsigned NREQ  = NUM_SRC + 1;
  localparam int unsigned DEPTH = NUM_SRC + 2;
  localparam logic [W-1:0] IDLE = W'(NUM_SRC + 1);

  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [AGE_W-1:0]   thr_q, thr_d;
  logic [NUM_SRC-1:0] force_q, force_d, elig_d;
  logic [NREQ-1:0]    pend_q, pend_d, clr;
  logic [W-1:0]       act_q, act_d, vec_q, vec_d;
  logic [W-1:0]       sel_id, sel_lvl, svc_lvl, stk_top;
  logic               irq_q, irq_d, sel_any;
  logic               ack_ok, eos_ok, stk_empty, stk_full;
  cfg_sel_e           wsel;

  assign wsel = cfg_sel_e'(wr_sel_i);

  // acknowledge and end-of-service qualification
  always_comb begin
    ack_ok = ack_i & irq_q & ~stk_full;
    eos_ok = eos_i & ~ack_ok & ~stk_empty;
    clr    = '0;
    if (ack_ok)
      clr[vec_q] = 1'b1;
    svc_lvl = (vec_q == W'(NUM_SRC)) ? '0 : vec_q + W'(1);
  end

  // configuration next state
  always_comb begin
    mask_d = mask_q;
    thr_d  = thr_q;
    if (wr_en_i && wsel == CFG_MASK)
      mask_d = wr_data_i[NUM_SRC-1:0];
    if (wr_en_i && wsel == CFG_AGE)
      thr_d = wr_data_i[AGE_W-1:0];
  end

  prio_irq_capture #(
    .N (NREQ)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .req_i    ({nmi_i, src_i}),
    .clr_i    (clr),
    .pend_q_o (pend_q),
    .pend_d_o (pend_d)
  );

  prio_irq_age #(
    .N     (NUM_SRC),
    .AGE_W (AGE_W)
  ) u_age (
    .clk       (clk),
    .rst       (rst),
    .pend_i    (pend_q[NUM_SRC-1:0]),
    .mask_i    (mask_q),
    .svc_i     (clr[NUM_SRC-1:0]),
    .thr_i     (thr_q),
    .force_q_o (force_q),
    .force_d_o (force_d)
  );

  prio_irq_stack #(
    .DEPTH (DEPTH),
    .W     (W)
  ) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push_i  (ack_ok),
    .pop_i   (eos_ok),
    .din_i   (act_q),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  // active level next state
  always_comb begin
    if (ack_ok)
      act_d = svc_lvl;
    else if (eos_ok)
      act_d = stk_top;
    else
      act_d = act_q;
  end

  // selection is made on next-state values so outputs match the stored state
  assign elig_d = pend_d[NUM_SRC-1:0] & (~mask_d | force_d);

  prio_irq_select #(
    .N (NUM_SRC),
    .W (W)
  ) u_select (
    .elig_i (elig_d),
    .nmi_i  (pend_d[NUM_SRC]),
    .any_o  (sel_any),
    .id_o   (sel_id),
    .lvl_o  (sel_lvl)
  );

  always_comb begin
    irq_d = sel_any && (sel_lvl < act_d);
    vec_d = irq_d ? sel_id : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      thr_q  <= AGE_W'(AGE_RST);
      act_q  <= IDLE;
      irq_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      mask_q <= mask_d;
      thr_q  <= thr_d;
      act_q  <= act_d;
      irq_q  <= irq_d;
      vec_q  <= vec_d;
    end
  end

  assign irq_o     = irq_q;
  assign vec_o     = vec_q;
  assign cur_lvl_o = act_q;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Port-level protocol checks, attached by bind.
module prio_irq_ctrl_chk #(
  parameter int unsigned NUM_SRC = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         ack_i,
  input logic                         eos_i,
  input logic                         irq_o,
  input logic [$clog2(NUM_SRC+2)-1:0] vec_o,
  input logic [$clog2(NUM_SRC+2)-1:0] cur_lvl_o
);

  localparam int unsigned W = $clog2(NUM_SRC + 2);
  localparam logic [W-1:0] IDLE = W'(NUM_SRC + 1);

  function automatic logic [W-1:0] lvl_of(logic [W-1:0] id);
    return (id == W'(NUM_SRC)) ? '0 : id + W'(1);
  endfunction

  // R3
  idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> vec_o == '0);

  // R3
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> vec_o <= W'(NUM_SRC));

  // R7
  irq_rank_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> lvl_of(vec_o) < cur_lvl_o);

  // R8
  ack_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o) |=> cur_lvl_o == lvl_of($past(vec_o)));

  // R8
  lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack_i && !eos_i) |=> $stable(cur_lvl_o));

  // R9
  eos_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (eos_i && !(ack_i && irq_o) && cur_lvl_o != IDLE) |=> cur_lvl_o > $past(cur_lvl_o));

  // R9
  eos_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (eos_i && !ack_i && cur_lvl_o == IDLE) |=> cur_lvl_o == IDLE);

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_SRC (NUM_SRC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack_i     (ack_i),
  .eos_i     (eos_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .cur_lvl_o (cur_lvl_o)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

  localparam int N    = 8;
  localparam int IDLE = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src = '0;
  logic        nmi = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ack = 1'b0;
  logic        eos = 1'b0;
  logic        irq;
  logic [3:0]  vec;
  logic [3:0]  lvl;

  always #2 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src),
    .nmi_i     (nmi),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .ack_i     (ack),
    .eos_i     (eos),
    .irq_o     (irq),
    .vec_o     (vec),
    .cur_lvl_o (lvl)
  );

  int    vectors = 0;
  int    errors  = 0;
  string cur_req = "R1";
  bit    done    = 0;

  // behavioural reference state
  bit       m_pend [N+1];
  bit [7:0] m_mask;
  int       m_thr;
  int       m_age  [N];
  bit       m_forced [N];
  int       m_act;
  int       m_stk [$];
  bit [8:0] m_prev;
  bit       m_irq;
  int       m_vec;

  function automatic int lvl_of(int id);
    return (id == N) ? 0 : id + 1;
  endfunction

  function automatic void m_eval();
    int best;
    best = -1;
    for (int k = N - 1; k >= 0; k--)
      if (m_pend[k] && (!m_mask[k] || m_forced[k])) best = k;
    if (m_pend[N]) best = N;
    m_irq = (best >= 0) && (lvl_of(best) < m_act);
    m_vec = m_irq ? best : 0;
  endfunction

  function automatic void m_reset();
    for (int k = 0; k <= N; k++) m_pend[k] = 0;
    for (int k = 0; k < N; k++) begin
      m_age[k] = 0;
      m_forced[k] = 0;
    end
    m_mask = '0;
    m_thr  = 15;
    m_act  = IDLE;
    m_stk.delete();
    m_prev = '0;
    m_eval();
  endfunction

  function automatic void m_step();
    bit [8:0] req;
    bit [8:0] rise;
    bit       taken;
    int       sid;
    req   = {nmi, src};
    rise  = req & ~m_prev;
    m_prev = req;
    taken = ack && m_irq && (m_stk.size() < N + 2);
    sid   = m_vec;
    for (int k = 0; k < N; k++) begin
      bit svc;
      bit waiting;
      bit nf;
      svc     = taken && (sid == k);
      waiting = m_pend[k] && m_mask[k] && !m_forced[k] && !svc;
      nf      = (m_forced[k] && !svc) || (waiting && (m_age[k] >= m_thr));
      m_age[k]    = waiting ? (m_age[k] + 1) % 256 : 0;
      m_forced[k] = nf;
    end
    for (int k = 0; k <= N; k++) begin
      if (taken && sid == k) m_pend[k] = 0;
      if (rise[k]) m_pend[k] = 1;
    end
    if (taken) begin
      m_stk.push_back(m_act);
      m_act = lvl_of(sid);
    end else if (eos && m_stk.size() > 0) begin
      m_act = m_stk.pop_back();
    end
    if (wr_en) begin
      if (wr_sel == 1'b0) m_mask = wr_data[7:0];
      else m_thr = int'(wr_data[7:0]);
    end
    m_eval();
  endfunction

  task automatic compare();
    vectors++;
    if (irq !== m_irq || vec !== 4'(m_vec) || lvl !== 4'(m_act)) begin
      errors++;
      $display("FAIL %s: irq/vec/lvl = %0d/%0d/%0d, expected %0d/%0d/%0d",
               cur_req, irq, vec, lvl, m_irq, m_vec, m_act);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (!rst) m_step();
    #1;
    if (!rst) compare();
    @(negedge clk);
  endtask

  task automatic chk(string req, bit e_irq, int e_vec, int e_lvl);
    vectors++;
    if (irq !== e_irq || vec !== 4'(e_vec) || lvl !== 4'(e_lvl)) begin
      errors++;
      $display("FAIL %s: irq/vec/lvl = %0d/%0d/%0d, expected %0d/%0d/%0d",
               req, irq, vec, lvl, e_irq, e_vec, e_lvl);
    end
  endtask

  task automatic ack_pulse();
    ack = 1'b1;
    cyc();
    ack = 1'b0;
  endtask

  task automatic eos_pulse();
    eos = 1'b1;
    cyc();
    eos = 1'b0;
  endtask

  task automatic wr(bit sel, int d);
    wr_en = 1'b1;
    wr_sel = sel;
    wr_data = 16'(d);
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog (R1..R9 sequence incomplete): cycles = 5000, expected finish earlier");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_reset();
    // R1 reset state
    chk("R1", 0, 0, IDLE);

    // R2 single source, held high
    cur_req = "R2";
    src = 8'h08; cyc(); chk("R2", 1, 3, IDLE);
    ack_pulse(); chk("R8", 0, 0, 4);
    cyc(); cyc(); chk("R2", 0, 0, 4);
    eos_pulse(); chk("R9", 0, 0, IDLE);
    src = 8'h00; cyc();

    // R3 simultaneous requests
    cur_req = "R3";
    src = 8'h24; cyc(); chk("R3", 1, 2, IDLE);
    ack_pulse(); chk("R7", 0, 0, 3);
    eos_pulse(); chk("R3", 1, 5, IDLE);
    ack_pulse(); eos_pulse();
    src = 8'h00; cyc();

    // R7 nested preemption
    cur_req = "R7";
    src = 8'h20; cyc(); ack_pulse();
    src = 8'h22; cyc(); chk("R7", 1, 1, 6);
    ack_pulse(); chk("R8", 0, 0, 2);
    src = 8'h2A; cyc(); chk("R7", 0, 0, 2);
    eos_pulse(); chk("R9", 1, 3, 6);
    ack_pulse(); chk("R8", 0, 0, 4);
    eos_pulse(); chk("R9", 0, 0, 6);
    eos_pulse(); chk("R9", 0, 0, IDLE);
    src = 8'h00; cyc();

    // R4 masking
    cur_req = "R4";
    wr(1'b1, 40); wr(1'b0, 8'h10);
    src = 8'h10; cyc(); cyc(); chk("R4", 0, 0, IDLE);
    src = 8'h50; cyc(); chk("R4", 1, 6, IDLE);
    ack_pulse(); eos_pulse(); chk("R4", 0, 0, IDLE);
    wr(1'b0, 0); chk("R4", 1, 4, IDLE);
    ack_pulse(); eos_pulse();
    src = 8'h00; cyc();

    // R5 non-maskable input
    cur_req = "R5";
    wr(1'b1, 200); wr(1'b0, 8'hFF);
    src = 8'h01; nmi = 1'b1; cyc(); chk("R5", 1, 8, IDLE);
    ack_pulse(); chk("R5", 0, 0, 0);
    eos_pulse(); chk("R5", 0, 0, IDLE);
    nmi = 1'b0; src = 8'h00;
    wr(1'b0, 0); chk("R4", 1, 0, IDLE);
    ack_pulse(); eos_pulse();

    // R6 aging promotion after threshold+1 cycles
    cur_req = "R6";
    wr(1'b1, 3); wr(1'b0, 8'h08);
    src = 8'h08; cyc();
    for (int i = 0; i < 3; i++) begin
      cyc(); chk("R6", 0, 0, IDLE);
    end
    cyc(); chk("R6", 1, 3, IDLE);
    ack_pulse(); chk("R6", 0, 0, 4);
    eos_pulse(); chk("R6", 0, 0, IDLE);
    src = 8'h00; cyc();

    // R6 unmasking restarts the wait count
    src = 8'h08; cyc(); cyc(); cyc();
    wr(1'b0, 0); chk("R6", 1, 3, IDLE);
    wr(1'b0, 8'h08); chk("R6", 0, 0, IDLE);
    for (int i = 0; i < 3; i++) begin
      cyc(); chk("R6", 0, 0, IDLE);
    end
    cyc(); chk("R6", 1, 3, IDLE);
    ack_pulse(); eos_pulse();
    src = 8'h00; cyc();

    // R8 / R9 ignored commands and collision
    cur_req = "R9";
    wr(1'b0, 0);
    ack_pulse(); chk("R8", 0, 0, IDLE);
    eos_pulse(); chk("R9", 0, 0, IDLE);
    src = 8'h20; cyc(); ack_pulse();
    src = 8'h24; cyc(); chk("R7", 1, 2, 6);
    ack = 1'b1; eos = 1'b1; cyc(); ack = 1'b0; eos = 1'b0;
    chk("R9", 0, 0, 3);
    eos_pulse(); chk("R9", 0, 0, 6);
    eos_pulse(); chk("R9", 0, 0, IDLE);
    src = 8'h00; cyc(); cyc();

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

endmodule